// File: doc/BRIEF.md
# ADC Output Data Formatter

This block sits between the converter cores of a four-channel ADC and the output drivers. Each channel delivers a signed conversion result together with a shared valid strobe. The block clamps the result to the 14-bit range and encodes it as offset binary. It can then flip it to two's complement and scramble it with the randomizer. A fixed test word can replace all of this, and a disable bit can blank everything. Control fields are sampled in the same cycle as a valid sample, so a mid-stream register change never splits a word.

A receive-side decoder is built in. It takes the formatted words and the receiver's own view of the format bits, and returns offset-binary codes, so the round trip can be checked end to end. Formatted words appear one clock after the sample that produced them.

Top module: `adc_out_fmt`

## Requirements
- R1: After reset, out_valid is 0, out_en is 0 and every out_words lane is 0.
- R2: With all mode bits clear, a sample v within [-8192, 8191] is output as v + 8192: 0 gives 0x2000, 8191 gives 0x3FFF, -8192 gives 0x0000.
- R3: A sample above 8191 is output as the positive full-scale code and a sample below -8192 as the negative full-scale code; the result never wraps.
- R4: With cfg_twos set, bit 13 of the offset-binary word is inverted: 0 gives 0x0000, 8191 gives 0x1FFF, -8192 gives 0x2000, -1 gives 0x3FFF.
- R5: With cfg_rand set, bits 13..1 of the word are each XORed with bit 0, and bit 0 is unchanged; this is applied after the two's complement step.
- R6: With cfg_tp_en set, every lane outputs {cfg_tp_hi[5:0], cfg_tp_lo[7:0]}, whatever cfg_twos and cfg_rand hold.
- R7: A sample taken with cfg_out_dis set drives out_valid 0, out_en 0 and all lanes 0 on the next cycle; the next sample taken with it clear turns out_en back on.
- R8: A sample accepted on in_valid shows on out_valid and out_words exactly one cycle later, formatted with the control values present in its own valid cycle.
- R9: In a cycle without in_valid, out_valid is 0 on the next cycle and out_words and out_en keep their values.
- R10: dec_words applies the inverse of the format given by rx_twos and rx_rand (un-scramble first, then undo the MSB flip), returning the offset-binary code.
- R11: Each lane is formatted only from its own 16-bit field of in_samples; lane c is bits [16c+15:16c] in and [14c+13:14c] out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe, shared by all lanes |
| in_samples | input | 64 | Four signed 16-bit conversion results, lane 0 in the low bits |
| cfg_twos | input | 1 | Two's complement output format |
| cfg_rand | input | 1 | Output randomizer enable |
| cfg_tp_en | input | 1 | Test pattern override |
| cfg_tp_hi | input | 6 | Test pattern bits 13..8 |
| cfg_tp_lo | input | 8 | Test pattern bits 7..0 |
| cfg_out_dis | input | 1 | Output disable |
| rx_twos | input | 1 | Decoder: words are two's complement |
| rx_rand | input | 1 | Decoder: words are randomized |
| out_valid | output | 1 | Formatted words valid |
| out_words | output | 56 | Four 14-bit formatted words, lane 0 in the low bits |
| out_en | output | 1 | Output drivers enabled |
| dec_words | output | 56 | Four decoded 14-bit offset-binary words |

## Verification
All state lives in one output register stage. A wrong captured word, valid bit or enable bit therefore appears at the ports on the cycle right after the sample that caused it. It is not hidden behind later stages. A control field latched in the wrong cycle shows up as the format of a neighbouring sample, so the bench changes the mode bits between samples and while idle. A decoder mismatch only shows with the randomizer and two's complement active together, so the round trip is run in that combination with odd and even codes.

// File: rtl/adc_fmt_pkg.sv
// Package: shared sizes for the ADC output formatter.
// Assumes the raw sample is wider than the output word and at most 32 bits.
package adc_fmt_pkg;
    localparam int DW     = 14;   // formatted word width
    localparam int RAW_W  = 16;   // signed converter result width
    localparam int NCH    = 4;    // channel count
    localparam int TP_HI_W = DW - 8;
endpackage

// File: rtl/fmt_lane.sv
// Module: fmt_lane
// Formats one channel combinationally: clamp, offset binary, optional
// MSB flip (two's complement), optional LSB-XOR randomizer, and the test
// pattern override. Assumes RAW_W > DW and RAW_W <= 32.
module fmt_lane #(
    parameter int DW    = 14,
    parameter int RAW_W = 16
) (
    input  logic [RAW_W-1:0] raw,
    input  logic             twos,
    input  logic             rnd,
    input  logic             tp_en,
    input  logic [DW-1:0]    tp,
    output logic [DW-1:0]    word
);
    localparam int HI_LIM = (2 ** (DW - 1)) - 1;
    localparam int LO_LIM = -(2 ** (DW - 1));

    logic signed [RAW_W-1:0] s_raw;
    logic [DW-1:0] ob;
    logic [DW-1:0] fmt;
    logic [DW-1:0] scr;

    assign s_raw = $signed(raw);

    // Saturate to the word range and encode as offset binary.
    always_comb begin
        if (int'(s_raw) > HI_LIM) begin
            ob = '1;
        end else if (int'(s_raw) < LO_LIM) begin
            ob = '0;
        end else begin
            ob = {~s_raw[DW-1], s_raw[DW-2:0]};
        end
    end

    // Two's complement by inverting the MSB of the offset-binary word.
    always_comb begin
        fmt = ob;
        if (twos) begin
            fmt[DW-1] = ~ob[DW-1];
        end
    end

    // Randomizer: fold the LSB into every upper bit, keep the LSB itself.
    always_comb begin
        scr = fmt;
        if (rnd) begin
            scr[DW-1:1] = fmt[DW-1:1] ^ {(DW-1){fmt[0]}};
        end
    end

    // Test pattern wins over every other mode.
    assign word = tp_en ? tp : scr;
endmodule

// File: rtl/fmt_out_stage.sv
// Module: fmt_out_stage
// The single register stage of the formatter. It captures formatted words,
// valid and the enable flag on each valid sample; when the sample is taken
// with the disable bit set, it blanks the words and drops valid and enable.
// Assumes the words at its input were built from the same cycle's controls.
module fmt_out_stage #(
    parameter int W = 56
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic         dis,
    input  logic [W-1:0] words_d,
    output logic         valid_q,
    output logic         en_q,
    output logic [W-1:0] words_q
);
    // Capture on sample boundaries; hold words and enable between samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            en_q    <= 1'b0;
            words_q <= '0;
        end else if (smp_valid) begin
            valid_q <= ~dis;
            en_q    <= ~dis;
            words_q <= dis ? '0 : words_d;
        end else begin
            valid_q <= 1'b0;
        end
    end

    AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!valid_q && words_q == '0)); // R7
endmodule

// File: rtl/derand_lane.sv
// Module: derand_lane
// Receive-side decoder for one lane: removes the randomizer first, then
// undoes the MSB flip, giving the offset-binary code. Purely combinational.
module derand_lane #(
    parameter int DW = 14
) (
    input  logic [DW-1:0] enc,
    input  logic          rx_twos,
    input  logic          rx_rand,
    output logic [DW-1:0] dec
);
    logic [DW-1:0] unscr;

    // Undo the randomizer; the LSB travels unchanged so it is the key.
    always_comb begin
        unscr = enc;
        if (rx_rand) begin
            unscr[DW-1:1] = enc[DW-1:1] ^ {(DW-1){enc[0]}};
        end
    end

    // Undo two's complement by flipping the MSB back.
    always_comb begin
        dec = unscr;
        if (rx_twos) begin
            dec[DW-1] = ~unscr[DW-1];
        end
    end

    // With both modes off the decoder must be transparent.
    always_comb begin
        if (!rx_twos && !rx_rand) begin
            AST_DEC_PASS: assert (dec == enc); // R10
        end
    end
endmodule

// File: rtl/adc_out_fmt.sv
// Module: adc_out_fmt
// Top of the ADC output formatter. It builds the test word, formats every
// lane in parallel, registers the result once, and decodes the registered
// words for receive-side checking. Assumes in_valid is shared by all lanes
// and that the control fields are meaningful in every in_valid cycle.
module adc_out_fmt
    import adc_fmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [NCH*RAW_W-1:0] in_samples,
    input  logic                 cfg_twos,
    input  logic                 cfg_rand,
    input  logic                 cfg_tp_en,
    input  logic [TP_HI_W-1:0]   cfg_tp_hi,
    input  logic [7:0]           cfg_tp_lo,
    input  logic                 cfg_out_dis,
    input  logic                 rx_twos,
    input  logic                 rx_rand,
    output logic                 out_valid,
    output logic [NCH*DW-1:0]    out_words,
    output logic                 out_en,
    output logic [NCH*DW-1:0]    dec_words
);
    localparam int WORDS_W = NCH * DW;

    logic [DW-1:0]      tp_word;
    logic [WORDS_W-1:0] fmt_words;

    // Join the two pattern bytes into one word.
    assign tp_word = {cfg_tp_hi, cfg_tp_lo};

    // One formatter and one decoder per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        fmt_lane #(.DW(DW), .RAW_W(RAW_W)) u_fmt (
            .raw   (in_samples[c*RAW_W +: RAW_W]),
            .twos  (cfg_twos),
            .rnd   (cfg_rand),
            .tp_en (cfg_tp_en),
            .tp    (tp_word),
            .word  (fmt_words[c*DW +: DW])
        );

        derand_lane #(.DW(DW)) u_dec (
            .enc     (out_words[c*DW +: DW]),
            .rx_twos (rx_twos),
            .rx_rand (rx_rand),
            .dec     (dec_words[c*DW +: DW])
        );
    end

    fmt_out_stage #(.W(WORDS_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (in_valid),
        .dis       (cfg_out_dis),
        .words_d   (fmt_words),
        .valid_q   (out_valid),
        .en_q      (out_en),
        .words_q   (out_words)
    );

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_out_dis) |=> (out_valid && out_en)); // R8

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_out_dis) |=> (!out_valid && !out_en && out_words == '0)); // R7

    AST_TP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_tp_en && !cfg_out_dis) |=>
        (out_words == {NCH{$past({cfg_tp_hi, cfg_tp_lo})}})); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_words) && $stable(out_en))); // R9
endmodule

// File: tb/adc_out_fmt_tb.sv
`timescale 1ns/1ps
// Directed bench for adc_out_fmt: one task per scenario, each checking itself.
module adc_out_fmt_tb;
    localparam int DW = 14;
    localparam int RW = 16;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NC*RW-1:0] in_samples = '0;
    logic cfg_twos = 1'b0, cfg_rand = 1'b0, cfg_tp_en = 1'b0, cfg_out_dis = 1'b0;
    logic [5:0] cfg_tp_hi = '0;
    logic [7:0] cfg_tp_lo = '0;
    logic rx_twos = 1'b0, rx_rand = 1'b0;
    logic out_valid, out_en;
    logic [NC*DW-1:0] out_words, dec_words;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    adc_out_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .cfg_twos(cfg_twos), .cfg_rand(cfg_rand), .cfg_tp_en(cfg_tp_en),
        .cfg_tp_hi(cfg_tp_hi), .cfg_tp_lo(cfg_tp_lo), .cfg_out_dis(cfg_out_dis),
        .rx_twos(rx_twos), .rx_rand(rx_rand), .out_valid(out_valid),
        .out_words(out_words), .out_en(out_en), .dec_words(dec_words)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offset-binary code expected for a signed sample (R2, R3).
    function automatic logic [DW-1:0] ref_ob(input int v);
        if (v > 8191) return 14'h3FFF;
        if (v < -8192) return 14'h0000;
        return 14'(v + 8192);
    endfunction

    // Full formatted word expected for a sample (R4, R5).
    function automatic logic [DW-1:0] ref_fmt(input int v, input bit tw, input bit rn);
        logic [DW-1:0] w;
        w = ref_ob(v);
        if (tw) w = w ^ 14'h2000;
        if (rn && w[0]) w = w ^ 14'h3FFE;
        return w;
    endfunction

    // Present one sample on all lanes at a falling edge; outputs are read one edge later.
    task automatic send(input int v0, input int v1, input int v2, input int v3);
        @(negedge clk);
        in_samples = {16'(v3), 16'(v2), 16'(v1), 16'(v0)};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_lanes(input string req, input int v0, input int v1, input int v2,
                             input int v3, input bit tw, input bit rn);
        chk({req, " lane0"}, 64'(out_words[0 +: DW]),  64'(ref_fmt(v0, tw, rn)));
        chk({req, " lane1"}, 64'(out_words[14 +: DW]), 64'(ref_fmt(v1, tw, rn)));
        chk({req, " lane2"}, 64'(out_words[28 +: DW]), 64'(ref_fmt(v2, tw, rn)));
        chk({req, " lane3"}, 64'(out_words[42 +: DW]), 64'(ref_fmt(v3, tw, rn)));
    endtask

    task automatic t_reset();
        chk("R1 valid", 64'(out_valid), 64'd0);
        chk("R1 en", 64'(out_en), 64'd0);
        chk("R1 words", 64'(out_words), 64'd0);
    endtask

    task automatic t_offset_binary();
        cfg_twos = 0; cfg_rand = 0; rx_twos = 0; rx_rand = 0;
        send(0, 8191, -8192, 1);
        chk("R8 valid one cycle later", 64'(out_valid), 64'd1);
        chk("R2 zero code", 64'(out_words[0 +: DW]), 64'h2000);
        chk("R2 R11 lanes", 64'(out_words), {8'd0, 14'h2001, 14'h0000, 14'h3FFF, 14'h2000});
    endtask

    task automatic t_clamp();
        send(9000, -9000, 32767, -32768);
        chk("R3 clamp", 64'(out_words), {8'd0, 14'h0000, 14'h3FFF, 14'h0000, 14'h3FFF});
    endtask

    task automatic t_twos();
        cfg_twos = 1;
        send(0, 8191, -8192, -1);
        chk("R4 twos", 64'(out_words), {8'd0, 14'h3FFF, 14'h2000, 14'h1FFF, 14'h0000});
        rx_twos = 1;
        #0.1 chk("R10 decode twos", 64'(dec_words[14 +: DW]), 64'h3FFF);
        cfg_twos = 0; rx_twos = 0;
    endtask

    task automatic t_random();
        cfg_rand = 1; rx_rand = 1;
        send(1, 2, -3, 8191);
        chk("R5 rand explicit", 64'(out_words[0 +: DW]), 64'h1FFF);
        chk_lanes("R5 rand", 1, 2, -3, 8191, 0, 1);
        chk("R10 decode rand", 64'(dec_words[0 +: DW]), 64'(ref_ob(1)));
        cfg_twos = 1; rx_twos = 1;
        send(5, -7, 100, -8192);
        chk_lanes("R5 twos then rand", 5, -7, 100, -8192, 1, 1);
        chk("R10 round trip lane1", 64'(dec_words[14 +: DW]), 64'(ref_ob(-7)));
        chk("R10 round trip lane2", 64'(dec_words[28 +: DW]), 64'(ref_ob(100)));
        cfg_twos = 0; cfg_rand = 0; rx_twos = 0; rx_rand = 0;
    endtask

    task automatic t_test_pattern();
        cfg_twos = 1; cfg_rand = 1; cfg_tp_en = 1;
        cfg_tp_hi = 6'h2D; cfg_tp_lo = 8'h5B;
        send(0, 1, 2, 3);
        chk("R6 pattern all lanes", 64'(out_words), {8'd0, {4{14'h2D5B}}});
        cfg_tp_en = 0;
        send(0, 1, 2, 3);
        chk_lanes("R6 pattern released", 0, 1, 2, 3, 1, 1);
        cfg_twos = 0; cfg_rand = 0;
    endtask

    task automatic t_disable();
        cfg_out_dis = 1;
        send(100, 200, 300, 400);
        chk("R7 valid off", 64'(out_valid), 64'd0);
        chk("R7 en off", 64'(out_en), 64'd0);
        chk("R7 words blank", 64'(out_words), 64'd0);
        cfg_out_dis = 0;
        send(100, 200, 300, 400);
        chk("R7 en restored", 64'(out_en), 64'd1);
        chk_lanes("R7 data restored", 100, 200, 300, 400, 0, 0);
    endtask

    task automatic t_hold();
        logic [NC*DW-1:0] prev;
        send(-50, 60, -70, 80);
        prev = out_words;
        @(negedge clk);
        chk("R9 valid drops", 64'(out_valid), 64'd0);
        chk("R9 words held", 64'(out_words), 64'(prev));
        chk("R9 en held", 64'(out_en), 64'd1);
    endtask

    task automatic t_cfg_boundary();
        // Mode changed while idle must not touch the held words.
        logic [NC*DW-1:0] prev;
        prev = out_words;
        @(negedge clk);
        cfg_twos = 1;
        @(negedge clk);
        chk("R8 idle cfg change", 64'(out_words), 64'(prev));
        send(10, 20, 30, 40);
        chk_lanes("R8 cfg at sample", 10, 20, 30, 40, 1, 0);
        cfg_twos = 0;
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offset_binary();
        t_clamp();
        t_twos();
        t_random();
        t_test_pattern();
        t_disable();
        t_hold();
        t_cfg_boundary();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule